// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a clocked on-chip request bus and an external asynchronous static RAM of 32K sixteen-bit words. A requester offers one operation at a time with a valid/ready handshake: a read or a write, a word address, write data and a two-bit lane mask. The block turns each operation into a sequence on the RAM's active-low select, write strobe, output enable and two lane enables. It also drives the shared data bus when writing and releases it otherwise. The block then signals completion with a one-cycle done strobe and, for reads, a registered data word.

Each phase of the pin sequence is a whole number of clock cycles. The count is derived from nanosecond limits and the clock period, given as parameters, so retargeting to another clock needs only a parameter change. All RAM pins come straight from flip-flops, so they change only on a clock edge and carry no decode glitches.

Top module: `asram_port`

## Requirements
- R1: During and after reset, chip select, write strobe, output enable and both lane enables are high, the data bus driver is off, `req_ready` is 1 and `rsp_done` is 0.
- R2: A write holds chip select and write strobe low for exactly WR_CYC cycles, where WR_CYC = max(1, ceil(T_WR_PS / CLK_PS)). Output enable stays high. Mask bit 0 pulls the low-lane enable (data bits 7:0) low and mask bit 1 pulls the high-lane enable (bits 15:8) low. Address and write data are driven and stable for the whole strobe.
- R3: A write ends on a single edge where write strobe, chip select and the lane enables all rise together and the data driver turns off.
- R4: A read holds chip select and output enable low, with write strobe high and the data driver off, for exactly RD_CYC = max(1, ceil(T_RD_PS / CLK_PS)) cycles. The lane enables follow the mask as in R2.
- R5: Read data is captured on the edge that ends the last read cycle. A lane whose mask bit is 1 returns the RAM's byte; a lane whose mask bit is 0 returns 0x00. `rsp_rdata` then holds its value through writes and empty requests until the next read completes.
- R6: The block drives the data bus only while chip select and write strobe are low and output enable is high, so it never drives the bus while the RAM does.
- R7: A write accepted when the last non-empty operation was a read starts its pins one cycle after the accepting edge, after an idle turnaround cycle. Any other non-empty operation starts its pins on the accepting edge.
- R8: A request with mask 00 produces no pin activity and raises `rsp_done` in the cycle right after the accepting edge.
- R9: `req_ready` is low from the accepting edge until `rsp_done` falls. `rsp_done` lasts one cycle. A non-empty operation raises done one cycle after its pins return idle.
- R10: With the default 5 ns clock and limits of 8 ns (write) and 10 ns (read), WR_CYC and RD_CYC are both 2, so a write or read from idle completes 3 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Lane mask, bit 0 = bits 7:0 |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DW | Last read data, disabled lanes zero |
| ram_addr | output | AW | RAM address pins |
| ram_dq_o | output | DW | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | DW | Data bus as seen from the pads |
| ram_ce_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_lb_n | output | 1 | Low-lane enable, active low |
| ram_ub_n | output | 1 | High-lane enable, active low |

## Verification
Two events share a clock edge: the read-data capture and the release of the read pins. The same edge that latches the data also raises output enable, and the next request may be offered in the very cycle `req_ready` returns. The RAM model in the bench drives unknown data until its access time has passed and stops driving the moment output enable rises. A capture one edge early, or one edge late, therefore returns a wrong or unknown word, and the comparison against the reference catches it. A write placed directly after a read is timed from its accepting edge to check that the turnaround cycle is present, and a bus monitor counts any cycle in which both sides drive the bus.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM sequencer.
// Assumes integer picosecond timing values and a non-zero clock period.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR,
        ST_RD,
        ST_DONE
    } asram_st_e;

    // Cycles needed to cover a limit: ceiling of limit/period, never below one.
    function automatic int unsigned clk_count(input int unsigned lim_ps,
                                              input int unsigned clk_ps);
        int unsigned c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Operation sequencer: accepts one request at a time, walks the phase
// states and counts the cycles of each strobe phase.
// Assumes WR_CYC and RD_CYC are at least one and fit in CW bits.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned WR_CYC = 2,
    parameter int unsigned RD_CYC = 2,
    parameter int unsigned CW     = 2,
    parameter int unsigned LN     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [LN-1:0]   req_mask,
    output asram_st_e       st_nxt,
    output logic            accept,
    output logic            ready,
    output logic            done,
    output logic            cap_en
);

    asram_st_e      st;
    logic [CW-1:0]  cnt, cnt_nxt;
    logic           last_rd, last_rd_nxt;

    assign ready  = (st == ST_IDLE);
    assign accept = req_valid && ready;
    assign done   = (st == ST_DONE);
    assign cap_en = (st == ST_RD) && (cnt == '0);

    // Next state, phase counter and last-operation flag.
    always_comb begin
        st_nxt      = st;
        cnt_nxt     = cnt;
        last_rd_nxt = last_rd;
        case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (req_mask == '0) begin
                        st_nxt = ST_DONE;
                    end else if (req_write) begin
                        if (last_rd) begin
                            st_nxt = ST_TURN;
                        end else begin
                            st_nxt      = ST_WR;
                            cnt_nxt     = CW'(WR_CYC - 1);
                            last_rd_nxt = 1'b0;
                        end
                    end else begin
                        st_nxt      = ST_RD;
                        cnt_nxt     = CW'(RD_CYC - 1);
                        last_rd_nxt = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                st_nxt      = ST_WR;
                cnt_nxt     = CW'(WR_CYC - 1);
                last_rd_nxt = 1'b0;
            end
            ST_WR, ST_RD: begin
                if (cnt == '0) st_nxt = ST_DONE;
                else           cnt_nxt = cnt - 1'b1;
            end
            ST_DONE: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            last_rd <= 1'b0;
        end else begin
            st      <= st_nxt;
            cnt     <= cnt_nxt;
            last_rd <= last_rd_nxt;
        end
    end

endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
// Pin driver: latches the accepted request and registers every RAM pin
// from the sequencer's next state, so pins move only on clock edges.
// Assumes two byte lanes (lane 0 = low enable, lane 1 = high enable).
module asram_pins
    import asram_pkg::*;
#(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 16,
    parameter int unsigned LN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  asram_st_e       st_nxt,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [LN-1:0]   req_mask,
    output logic [LN-1:0]   mask_q,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_dq_o,
    output logic            ram_dq_oe,
    output logic            ram_ce_n,
    output logic            ram_we_n,
    output logic            ram_oe_n,
    output logic            ram_lb_n,
    output logic            ram_ub_n
);

    logic [LN-1:0] use_mask;
    logic          go_wr, go_rd, go_act;

    assign use_mask = accept ? req_mask : mask_q;
    assign go_wr    = (st_nxt == ST_WR);
    assign go_rd    = (st_nxt == ST_RD);
    assign go_act   = go_wr || go_rd;

    // Request latch: address, data and mask held for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            ram_addr <= '0;
            ram_dq_o <= '0;
        end else if (accept) begin
            mask_q   <= req_mask;
            ram_addr <= req_addr;
            ram_dq_o <= req_wdata;
        end
    end

    // Registered strobes and bus direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce_n  <= 1'b1;
            ram_we_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_lb_n  <= 1'b1;
            ram_ub_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
        end else begin
            ram_ce_n  <= !go_act;
            ram_we_n  <= !go_wr;
            ram_oe_n  <= !go_rd;
            ram_lb_n  <= !(go_act && use_mask[0]);
            ram_ub_n  <= !(go_act && use_mask[1]);
            ram_dq_oe <= go_wr;
        end
    end

endmodule

// File: rtl/asram_capture.sv
`timescale 1ns/1ps
// Read capture: registers each enabled lane of the bus at the end of the
// access window; disabled lanes load zero. Holds until the next capture.
// Assumes DW is a whole number of bytes.
module asram_capture #(
    parameter int unsigned DW = 16,
    parameter int unsigned LN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [LN-1:0]   mask_q,
    input  logic [DW-1:0]   dq_i,
    output logic [DW-1:0]   rdata
);

    for (genvar g = 0; g < LN; g++) begin : g_lane
        // Per-lane capture register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[g*8 +: 8] <= '0;
            else if (cap_en)
                rdata[g*8 +: 8] <= mask_q[g] ? dq_i[g*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/asram_port.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM sequencer: request handshake in, registered
// RAM pin sequence out, read data and done strobe back.
// Assumes DW = 16 (two lanes) and timing limits given in picoseconds.
module asram_port
    import asram_pkg::*;
#(
    parameter int unsigned AW       = 15,
    parameter int unsigned DW       = 16,
    parameter int unsigned CLK_PS   = 5000,
    parameter int unsigned T_WR_PS  = 8000,
    parameter int unsigned T_RD_PS  = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_mask,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     ram_addr,
    output logic [DW-1:0]     ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DW-1:0]     ram_dq_i,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_lb_n,
    output logic              ram_ub_n
);

    localparam int unsigned LN     = DW / 8;
    localparam int unsigned WR_CYC = clk_count(T_WR_PS, CLK_PS);
    localparam int unsigned RD_CYC = clk_count(T_RD_PS, CLK_PS);
    localparam int unsigned MX_CYC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int unsigned CW     = (MX_CYC < 2) ? 1 : $clog2(MX_CYC);

    asram_st_e      st_nxt;
    logic           accept, cap_en;
    logic [LN-1:0]  mask_q;

    asram_seq #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .CW(CW), .LN(LN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mask  (req_mask),
        .st_nxt    (st_nxt),
        .accept    (accept),
        .ready     (req_ready),
        .done      (rsp_done),
        .cap_en    (cap_en)
    );

    asram_pins #(.AW(AW), .DW(DW), .LN(LN)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .st_nxt    (st_nxt),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .mask_q    (mask_q),
        .ram_addr  (ram_addr),
        .ram_dq_o  (ram_dq_o),
        .ram_dq_oe (ram_dq_oe),
        .ram_ce_n  (ram_ce_n),
        .ram_we_n  (ram_we_n),
        .ram_oe_n  (ram_oe_n),
        .ram_lb_n  (ram_lb_n),
        .ram_ub_n  (ram_ub_n)
    );

    asram_capture #(.DW(DW), .LN(LN)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .mask_q (mask_q),
        .dq_i   (ram_dq_i),
        .rdata  (rsp_rdata)
    );

endmodule

// File: rtl/asram_port_chk.sv
`timescale 1ns/1ps
// Protocol checker for asram_port: strobe widths, bus ownership and
// handshake rules, observed at the pins. Bound to every asram_port.
module asram_port_chk
    import asram_pkg::*;
#(
    parameter int unsigned AW      = 15,
    parameter int unsigned DW      = 16,
    parameter int unsigned CLK_PS  = 5000,
    parameter int unsigned T_WR_PS = 8000,
    parameter int unsigned T_RD_PS = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic              req_valid,
    input logic [DW/8-1:0]   req_mask,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     dq_o,
    input logic              dq_oe,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              lb_n,
    input logic              ub_n
);

    localparam int unsigned WR_CYC = clk_count(T_WR_PS, CLK_PS);
    localparam int unsigned RD_CYC = clk_count(T_RD_PS, CLK_PS);

    logic [15:0] wlo, olo;

    // Length of the current low run on write strobe and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlo <= '0;
            olo <= '0;
        end else begin
            wlo <= !we_n ? wlo + 1'b1 : 16'd0;
            olo <= !oe_n ? olo + 1'b1 : 16'd0;
        end
    end

    a_r2_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wlo == 16'(WR_CYC)));
    a_r2_stable_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_o) && oe_n));
    a_r3_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (!dq_oe && ce_n && lb_n && ub_n));
    a_r4_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (olo == 16'(RD_CYC)));
    a_r4_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n && !dq_oe));
    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !ce_n && oe_n));
    a_r8_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_mask == '0) |=> (done && ce_n));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

endmodule

bind asram_port asram_port_chk #(
    .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .T_WR_PS(T_WR_PS), .T_RD_PS(T_RD_PS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (req_ready),
    .done      (rsp_done),
    .req_valid (req_valid),
    .req_mask  (req_mask),
    .addr      (ram_addr),
    .dq_o      (ram_dq_o),
    .dq_oe     (ram_dq_oe),
    .ce_n      (ram_ce_n),
    .we_n      (ram_we_n),
    .oe_n      (ram_oe_n),
    .lb_n      (ram_lb_n),
    .ub_n      (ram_ub_n)
);

// File: tb/asram_port_test.sv
`timescale 1ns/1ps
// Directed bench for asram_port with a lane-aware asynchronous RAM model.
module asram_port_test;

    localparam int CLK_PS  = 5000;
    localparam int T_WR_PS = 8000;
    localparam int T_RD_PS = 10000;
    localparam int WR_EXP  = 2;   // 8 ns over 5 ns, rounded up
    localparam int RD_EXP  = 2;   // 10 ns over 5 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic req_ready, rsp_done, ram_dq_oe;
    logic ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
    logic [15:0] rsp_rdata, ram_dq_o, bus, ram_drv;
    logic [14:0] ram_addr;
    logic rd_sel;

    int n_chk = 0, n_fail = 0;
    int wrun = 0, orun = 0, rsel = 0, wlow_last = 0, olow_last = 0;
    int r3_bad = 0, r6_bad = 0;
    logic [1:0] wl_acc = '0, wlanes_last = '0;
    logic [15:0] ram [int];
    logic [15:0] refm [int];

    always #2.5 clk = ~clk;

    asram_port #(.CLK_PS(CLK_PS), .T_WR_PS(T_WR_PS), .T_RD_PS(T_RD_PS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
        .ram_dq_i(bus), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n)
    );

    // RAM model: drives only selected lanes, only while read-selected.
    assign rd_sel = !ram_ce_n && !ram_oe_n && ram_we_n;
    assign bus[7:0]  = ram_dq_oe ? ram_dq_o[7:0]  : (rd_sel && !ram_lb_n) ? ram_drv[7:0]  : 8'hzz;
    assign bus[15:8] = ram_dq_oe ? ram_dq_o[15:8] : (rd_sel && !ram_ub_n) ? ram_drv[15:8] : 8'hzz;

    function automatic logic [15:0] rd_word(input int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] ref_word(input int a);
        return refm.exists(a) ? refm[a] : 16'h0000;
    endfunction

    // Monitor and RAM model update, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            wrun = 0; orun = 0; rsel = 0; ram_drv = 'x;
        end else begin
            if (!ram_we_n) begin
                wrun++; wl_acc |= {!ram_ub_n, !ram_lb_n};
            end else if (wrun != 0) begin
                wlow_last = wrun; wlanes_last = wl_acc; wl_acc = '0; wrun = 0;
                if (ram_dq_oe || !ram_ce_n || !ram_lb_n || !ram_ub_n) r3_bad++;
            end
            if (!ram_oe_n) orun++;
            else if (orun != 0) begin olow_last = orun; orun = 0; end
            if (ram_dq_oe && (ram_we_n || ram_ce_n || !ram_oe_n)) r6_bad++;
            if (!ram_ce_n && !ram_we_n) begin
                logic [15:0] w;
                w = rd_word(int'(ram_addr));
                if (!ram_dq_oe) r6_bad++;
                if (!ram_lb_n) w[7:0]  = ram_dq_o[7:0];
                if (!ram_ub_n) w[15:8] = ram_dq_o[15:8];
                ram[int'(ram_addr)] = w;
            end
            if (rd_sel) begin
                rsel++;
                ram_drv = (rsel * CLK_PS >= T_RD_PS) ? rd_word(int'(ram_addr)) : 'x;
            end else begin
                rsel = 0; ram_drv = 'x;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // One request; lat = negedges from acceptance to done, act = first pin cycle.
    task automatic do_req(input logic wr, input logic [14:0] a, input logic [15:0] d,
                          input logic [1:0] m, output int lat, output int act);
        int busy_bad = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) step();
        lat = 0; act = -1;
        do begin
            step(); lat++;
            if (lat == 1) req_valid = 1'b0;
            if (!ram_ce_n && act < 0) act = lat - 1;
            if (req_ready) busy_bad++;
        end while (!rsp_done && lat < 50);
        chk(busy_bad == 0, "R9", "ready high while busy", busy_bad, 0);
        step();
        chk(!rsp_done && req_ready, "R9", "done one cycle then ready", {rsp_done, req_ready}, 2'b01);
        if (wr) refm[int'(a)] = {m[1] ? d[15:8] : ref_word(int'(a))[15:8],
                                 m[0] ? d[7:0]  : ref_word(int'(a))[7:0]};
    endtask

    task automatic t_reset();
        chk({ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ram_dq_oe} == 6'b111110,
            "R1", "idle pins", {ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ram_dq_oe}, 6'b111110);
        chk(req_ready && !rsp_done, "R1", "ready/done", {req_ready, rsp_done}, 2'b10);
    endtask

    task automatic t_write_read();
        int lat, act;
        do_req(1'b1, 15'h0005, 16'hA55A, 2'b11, lat, act);
        chk(wlow_last == WR_EXP, "R10", "write strobe cycles", wlow_last, WR_EXP);
        chk(wlanes_last == 2'b11, "R2", "write lanes", wlanes_last, 2'b11);
        chk(act == 0 && lat == WR_EXP + 1, "R9", "write latency", lat, WR_EXP + 1);
        do_req(1'b0, 15'h0005, 16'h0, 2'b11, lat, act);
        chk(olow_last == RD_EXP, "R4", "read enable cycles", olow_last, RD_EXP);
        chk(rsp_rdata == 16'hA55A, "R5", "read data", rsp_rdata, 16'hA55A);
        chk(lat == RD_EXP + 1, "R10", "read latency", lat, RD_EXP + 1);
    endtask

    task automatic t_turnaround();
        int lat, act;
        do_req(1'b1, 15'h0006, 16'h00C3, 2'b01, lat, act);
        chk(act == 1, "R7", "write after read start", act, 1);
        chk(wlanes_last == 2'b01, "R2", "low lane only", wlanes_last, 2'b01);
        do_req(1'b1, 15'h0006, 16'h3C00, 2'b10, lat, act);
        chk(act == 0, "R7", "write after write start", act, 0);
        chk(wlanes_last == 2'b10, "R2", "high lane only", wlanes_last, 2'b10);
    endtask

    task automatic t_lanes();
        int lat, act;
        do_req(1'b1, 15'h0007, 16'h1234, 2'b11, lat, act);
        do_req(1'b1, 15'h0007, 16'hFFAB, 2'b01, lat, act);
        do_req(1'b0, 15'h0007, 16'h0, 2'b10, lat, act);
        chk(rsp_rdata == 16'h1200, "R5", "high lane read, low zero", rsp_rdata, 16'h1200);
        do_req(1'b0, 15'h0007, 16'h0, 2'b01, lat, act);
        chk(rsp_rdata == 16'h00AB, "R5", "low lane read, high zero", rsp_rdata, 16'h00AB);
        do_req(1'b1, 15'h0008, 16'h5555, 2'b11, lat, act);
        chk(rsp_rdata == 16'h00AB, "R5", "read data held over write", rsp_rdata, 16'h00AB);
    endtask

    task automatic t_empty();
        int lat, act;
        do_req(1'b1, 15'h0007, 16'h9999, 2'b00, lat, act);
        chk(lat == 1 && act == -1, "R8", "empty write", lat, 1);
        do_req(1'b0, 15'h0007, 16'h0, 2'b00, lat, act);
        chk(lat == 1 && act == -1, "R8", "empty read", lat, 1);
        chk(rsp_rdata == 16'h00AB, "R8", "empty read keeps data", rsp_rdata, 16'h00AB);
        do_req(1'b0, 15'h0007, 16'h0, 2'b11, lat, act);
        chk(rsp_rdata == 16'h12AB, "R8", "empty write left RAM alone", rsp_rdata, 16'h12AB);
    endtask

    task automatic t_random();
        int lat, act, bad = 0;
        for (int i = 0; i < 16; i++) do_req(1'b1, 15'(15'h7FF0 + i), 16'(i * 16'h1111), 2'b11, lat, act);
        for (int i = 0; i < 40; i++)
            do_req(1'b1, 15'(15'h7FF0 + $urandom_range(0, 15)), 16'($urandom),
                   2'($urandom_range(0, 3)), lat, act);
        for (int i = 0; i < 16; i++) begin
            do_req(1'b0, 15'(15'h7FF0 + i), 16'h0, 2'b11, lat, act);
            if (rsp_rdata !== ref_word(15'h7FF0 + i)) begin
                bad++;
                chk(1'b0, "R5", "random masked read", rsp_rdata, ref_word(15'h7FF0 + i));
            end
        end
        chk(bad == 0, "R2", "random masked writes", bad, 0);
    endtask

    task automatic t_bus();
        chk(r6_bad == 0, "R6", "bus drive outside write window", r6_bad, 0);
        chk(r3_bad == 0, "R3", "write end not simultaneous", r3_bad, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write_read();
        t_turnaround();
        t_lanes();
        t_empty();
        t_random();
        t_bus();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule